// File: doc/BRIEF.md
# Spike-Woken Integrate-and-Fire Neuron

This block is one integrate-and-fire neuron whose controller sleeps until a spike arrives. It has two spike lines. A rising edge on the excitatory line raises a signed membrane potential by one. A rising edge on the inhibitory line lowers it by one. Each line has its own edge-capture flop. A captured edge sets a clock-request flag. One cycle later an ungate flag lets the small state machine advance. When the machine finds no pending work it clears both flags and the neuron goes back to sleep.

When an update brings the potential to the programmable threshold or above, the neuron clears the potential to zero and raises a firing request. The request stays high until an acknowledge returns. While it waits, the neuron stays awake and keeps integrating new spikes. The request and acknowledge pins form a simple hold-until-taken handshake. The request does not drop without an acknowledge, and an acknowledge that arrives with no request pending has no effect. Each layer of neurons drives its own threshold value. Typical values are small positive numbers such as 1, 10, 18 or 28.

Top module: `evn_neuron`

## Requirements
- R1: After reset, potential is 0 and fire_req, clk_request and fsm_clk_on are all 0.
- R2: A rising edge on spike_up adds one to the potential. Holding spike_up high for many cycles counts as a single spike.
- R3: A rising edge on spike_down subtracts one from the potential.
- R4: Rising edges on both lines in the same cycle leave the potential unchanged, and both captured edges are cleared, so neither is counted later.
- R5: clk_request rises in the cycle after an edge is captured, which is two clock edges after the input rises. fsm_clk_on rises one cycle after clk_request, never before it.
- R6: With no captured edge and no pending request, the state machine clears clk_request and fsm_clk_on together. While fsm_clk_on is low the potential does not change.
- R7: When an update makes the signed potential greater than or equal to the signed threshold, the potential becomes 0 and fire_req rises in the same cycle.
- R8: fire_req stays high until fire_ack is seen high. It falls on the clock edge that samples fire_ack. fire_ack while fire_req is low changes neither the potential, nor fire_req, nor clk_request.
- R9: While fire_req is pending, new spikes still change the potential by plus or minus one.
- R10: The 8-bit two's-complement potential saturates at -128 when decremented and at +127 when incremented. It never wraps.
- R11: The threshold input is signed and may change between spikes. The comparison of R7 uses its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from the shared generator, modelled as free-running |
| rst_n | input | 1 | Active-low synchronous reset |
| spike_up | input | 1 | Excitatory spike line, counted on its rising edge |
| spike_down | input | 1 | Inhibitory spike line, counted on its rising edge |
| threshold | input | 8 | Signed firing threshold |
| fire_ack | input | 1 | Acknowledge for the firing request |
| fire_req | output | 1 | Firing request, held until acknowledged |
| clk_request | output | 1 | Clock-enable flag, requests the shared clock |
| fsm_clk_on | output | 1 | Ungate flag, lets the state machine advance |
| potential | output | 8 | Signed membrane potential |

## Verification
The hardest situation to reach is spike integration while a firing request is pending.

To get there, the stimulus sets a small threshold and fires the neuron. It then withholds fire_ack while it pulses spike_up again, and checks both the growing potential and the held request before releasing fire_ack. Saturation needs more than a hundred paced inhibitory pulses, each followed by a full wake-update-sleep round, before the floor is reached. The pulse after that confirms that the count leaves the floor without wrapping.

// File: rtl/evn_pkg.sv
package evn_pkg;
  localparam int unsigned POT_W = 8;
  localparam int unsigned N_LINES = 2;
  localparam int unsigned LINE_UP = 0;
  localparam int unsigned LINE_DN = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_HOLD = 2'd2
  } nrn_state_e;
endpackage

// File: rtl/evn_edge_capture.sv
module evn_edge_capture #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] spk,
  input  logic             clr,
  output logic [LANES-1:0] cap
);
  logic [LANES-1:0] prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic rise;
    assign rise = spk[g] & ~prev_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        cap[g]    <= 1'b0;
      end else begin
        prev_q[g] <= spk[g];
        // a fresh edge wins over a clear in the same cycle
        cap[g]    <= rise | (cap[g] & ~clr);
      end
    end

    // R2: a held level is not recaptured once cleared
    p_level_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (spk[g] && $past(spk[g]) && !cap[g]) |=> !cap[g]);
  end
endmodule

// File: rtl/evn_clock_wake.sv
module evn_clock_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_any,
  input  logic sleep_req,
  output logic awake,
  output logic run
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      awake <= 1'b0;
      run   <= 1'b0;
    end else begin
      awake <= cap_any | (awake & ~sleep_req);
      // ungate only once the enable has been seen for a full cycle
      run   <= awake & ~sleep_req;
    end
  end

  // R5: the state machine clock never opens ahead of the request
  p_ungate_after_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(awake));
  // R6: the two flags fall together
  p_sleep_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !awake);
endmodule

// File: rtl/evn_if_core.sv
module evn_if_core
  import evn_pkg::*;
#(
  parameter int unsigned PW = POT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 cap_up,
  input  logic                 cap_dn,
  input  logic signed [PW-1:0] threshold,
  input  logic                 ack,
  output logic                 clr,
  output logic                 sleep_req,
  output logic                 req,
  output logic signed [PW-1:0] pot
);
  localparam logic signed [PW-1:0] PMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN = {1'b1, {(PW-1){1'b0}}};

  nrn_state_e st_q, st_n;
  logic signed [PW-1:0] pot_n, stepped;
  logic req_n;
  logic cap_any;

  assign cap_any = cap_up | cap_dn;

  always_comb begin
    stepped = pot;
    if (cap_up && !cap_dn && pot != PMAX) stepped = pot + PW'(1);
    if (cap_dn && !cap_up && pot != PMIN) stepped = pot - PW'(1);
  end

  always_comb begin
    st_n      = st_q;
    pot_n     = pot;
    req_n     = req;
    clr       = 1'b0;
    sleep_req = 1'b0;
    if (run) begin
      unique case (st_q)
        ST_IDLE: begin
          if (cap_any) st_n = ST_STEP;
          else         sleep_req = 1'b1;
        end
        ST_STEP: begin
          clr = 1'b1;
          if (stepped >= threshold) begin
            pot_n = '0;
            req_n = 1'b1;
            st_n  = ST_HOLD;
          end else begin
            pot_n = stepped;
            st_n  = ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (ack) begin
            req_n = 1'b0;
            st_n  = ST_IDLE;
          end else if (cap_any) begin
            clr   = 1'b1;
            pot_n = stepped;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pot  <= '0;
      req  <= 1'b0;
    end else begin
      st_q <= st_n;
      pot  <= pot_n;
      req  <= req_n;
    end
  end

  // R8: request holds without acknowledge
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  // R8: acknowledge retires a pending request on the next edge
  p_ack_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req);
  // R7: firing leaves the potential at zero
  p_fire_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (pot == '0));
  // R10: outside a fire the potential moves by at most one
  p_unit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(req) |-> (pot == $past(pot) || pot == PW'($past(pot) + PW'(1))
                     || pot == PW'($past(pot) - PW'(1))));
  // R6: a gated machine holds its potential
  p_gated_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pot));
endmodule

// File: rtl/evn_neuron.sv
module evn_neuron
  import evn_pkg::*;
#(
  parameter int unsigned PW = POT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spike_up,
  input  logic                 spike_down,
  input  logic signed [PW-1:0] threshold,
  input  logic                 fire_ack,
  output logic                 fire_req,
  output logic                 clk_request,
  output logic                 fsm_clk_on,
  output logic signed [PW-1:0] potential
);
  logic [N_LINES-1:0] caps;
  logic clr, sleep_req;

  evn_edge_capture #(.LANES(N_LINES)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .spk   ({spike_down, spike_up}),
    .clr   (clr),
    .cap   (caps)
  );

  evn_clock_wake u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_any   (|caps),
    .sleep_req (sleep_req),
    .awake     (clk_request),
    .run       (fsm_clk_on)
  );

  evn_if_core #(.PW(PW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (fsm_clk_on),
    .cap_up    (caps[LINE_UP]),
    .cap_dn    (caps[LINE_DN]),
    .threshold (threshold),
    .ack       (fire_ack),
    .clr       (clr),
    .sleep_req (sleep_req),
    .req       (fire_req),
    .pot       (potential)
  );
endmodule

// File: tb/test_evn_neuron.sv
module test_evn_neuron;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spike_up = 1'b0, spike_down = 1'b0, fire_ack = 1'b0;
  logic signed [7:0] threshold = 8'sd100;
  logic fire_req, clk_request, fsm_clk_on;
  logic signed [7:0] potential;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  evn_neuron i_evn_neuron (
    .clk(clk), .rst_n(rst_n), .spike_up(spike_up), .spike_down(spike_down),
    .threshold(threshold), .fire_ack(fire_ack), .fire_req(fire_req),
    .clk_request(clk_request), .fsm_clk_on(fsm_clk_on), .potential(potential)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic up, input logic dn);
    @(negedge clk);
    spike_up = up; spike_down = dn;
    @(negedge clk);
    spike_up = 1'b0; spike_down = 1'b0;
    idle(8);
  endtask

  task automatic t_reset;
    chk("R1 potential", potential, 0);
    chk("R1 fire_req", fire_req, 0);
    chk("R1 clk_request", clk_request, 0);
    chk("R1 fsm_clk_on", fsm_clk_on, 0);
  endtask

  task automatic t_wake;
    @(negedge clk); spike_up = 1'b1;
    @(negedge clk); spike_up = 1'b0;
    @(negedge clk);
    chk("R5 clk_request after capture", clk_request, 1);
    chk("R5 fsm_clk_on still gated", fsm_clk_on, 0);
    @(negedge clk);
    chk("R5 fsm_clk_on ungated", fsm_clk_on, 1);
    idle(6);
    chk("R2 potential +1", potential, 1);
    chk("R6 clk_request back low", clk_request, 0);
    chk("R6 fsm_clk_on back low", fsm_clk_on, 0);
  endtask

  task automatic t_level;
    @(negedge clk); spike_up = 1'b1;
    idle(20);
    chk("R2 held level counted once", potential, 2);
    spike_up = 1'b0;
    idle(8);
    chk("R2 after release", potential, 2);
  endtask

  task automatic t_dec;
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
    chk("R3 three decrements", potential, -1);
  endtask

  task automatic t_both;
    pulse(1'b1, 1'b1);
    chk("R4 simultaneous net zero", potential, -1);
    chk("R4 asleep afterwards", clk_request, 0);
    pulse(1'b1, 1'b0);
    chk("R4 no stale capture", potential, 0);
  endtask

  task automatic t_fire_wait;
    threshold = 8'sd3;
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
    chk("R7 below threshold no fire", fire_req, 0);
    chk("R11 potential 2", potential, 2);
    pulse(1'b1, 1'b0);
    chk("R7 fire_req raised", fire_req, 1);
    chk("R7 potential cleared", potential, 0);
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
    chk("R9 integrate while waiting", potential, 2);
    chk("R8 request held", fire_req, 1);
    chk("R8 stays awake", clk_request, 1);
    @(negedge clk); fire_ack = 1'b1;
    @(negedge clk); fire_ack = 1'b0;
    chk("R8 request retired", fire_req, 0);
    idle(6);
    chk("R8 asleep after ack", clk_request, 0);
    chk("R8 potential kept", potential, 2);
    pulse(1'b1, 1'b0);
    chk("R7 second fire", fire_req, 1);
    @(negedge clk); fire_ack = 1'b1;
    @(negedge clk); fire_ack = 1'b0;
    idle(6);
  endtask

  task automatic t_ack_ignored;
    pulse(1'b0, 1'b1);
    @(negedge clk); fire_ack = 1'b1;
    idle(5);
    chk("R8 stray ack no request", fire_req, 0);
    chk("R8 stray ack no wake", clk_request, 0);
    fire_ack = 1'b0;
    idle(3);
    chk("R8 stray ack potential", potential, -1);
  endtask

  task automatic t_thresh1;
    threshold = 8'sd1;
    pulse(1'b1, 1'b0);
    chk("R11 at 0 below 1", fire_req, 0);
    pulse(1'b1, 1'b0);
    chk("R11 threshold 1 fires", fire_req, 1);
    @(negedge clk); fire_ack = 1'b1;
    @(negedge clk); fire_ack = 1'b0;
    idle(6);
    chk("R11 potential zero", potential, 0);
  endtask

  task automatic t_saturate;
    threshold = 8'sd100;
    for (int i = 0; i < 140; i++) pulse(1'b0, 1'b1);
    chk("R10 floor -128", potential, -128);
    pulse(1'b1, 1'b0);
    chk("R10 leaves floor", potential, -127);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wake();
    t_level();
    t_dec();
    t_both();
    t_fire_wait();
    t_ack_ignored();
    t_thresh1();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule